// File: doc/BRIEF.md
# DMX512 Slot Receiver

This block takes a DMX512 stream from a single receive line and files every received slot into an on-chip byte array, one entry per slot. The bit time comes from a clock-frequency parameter divided by the 250 kbaud line rate. Each character has one start bit, eight data bits sent least significant bit first, and two stop bits. Three samples are taken around the centre of each bit, and a majority vote decides the bit value. A line break shows up as a character whose stop bit reads low. Such a framing error sends the write position back to index 0, so the next character, the start code, lands at the head of the array.

Downstream logic reads any stored slot through a synchronous read port. The value of slot 1 is also driven on its own output, so the first channel needs no read cycle. The block also outputs the current write position, a one-cycle pulse when the first character after a break is stored, a framing-error pulse, and a noise pulse.

Top module: `dmx_slot_receiver`

## Requirements
- R1: The bit period is CLK_HZ/BAUD_HZ clocks. A character is a low start bit, eight data bits with the least significant bit first, and two high stop bits. Each bit is decided by a majority vote of three consecutive samples taken at the middle of the bit.
- R2: A character with both stop bits high is written at the current write position `wr_ptr_o`, and the position then advances by one.
- R3: The array holds DEPTH entries (515 by default). A character written at index DEPTH-1 returns the position to 0.
- R4: A character whose first or second stop bit votes low, including a break, gives a one-cycle `frame_err_o` pulse. That character is not stored, and `wr_ptr_o` is 0 on the following cycle.
- R5: `frame_start_o` pulses for one cycle when the first character after a framing error has been stored, and `wr_ptr_o` reads 1 in that cycle. Characters stored later, or stored before any framing error has occurred, give no pulse.
- R6: `slot1_o` holds the last character stored at index 1.
- R7: If the three samples of any bit in a stored character disagree, `noise_err_o` pulses once for that character. The character is still stored with its majority-voted value, and reception carries on.
- R8: If the start bit votes high at its middle, the event is treated as a glitch. Nothing is stored and the position does not change.
- R9: `rd_data_o` returns the entry selected by `rd_addr_i` one clock after the address is applied. An address of DEPTH or more reads 0.
- R10: After reset, `wr_ptr_o` and `slot1_o` are 0 and all three pulse outputs are low.
- R11: After a framing error, the receiver waits for the line to return high before it looks for a new start bit. A break of any length therefore gives exactly one `frame_err_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high, asynchronous |
| rd_addr_i | input | AW | Index of the slot to read back |
| rd_data_o | output | 8 | Stored byte at the index applied on the previous clock |
| slot1_o | output | 8 | Last byte stored at index 1 |
| wr_ptr_o | output | AW | Index the next good character will be written to |
| frame_start_o | output | 1 | Pulse: first character after a framing error stored |
| frame_err_o | output | 1 | Pulse: stop bit sampled low (break or bad character) |
| noise_err_o | output | 1 | Pulse: a stored character had a disagreeing bit sample |

## Verification
The hardest case to reach from the line is a bit whose three centre samples disagree without the vote flipping. The glitch has to land on exactly one of the three sample clocks. The stimulus drives the line on falling clock edges, so the two-flop synchroniser and the start-detect latency place the samples at fixed clocks within each bit. The bench inverts the line for one clock at the centre sample only, and it also covers a three-clock low pulse that must be rejected as a false start. Wrap-around is reached by sending DEPTH+1 characters after a break at a shortened bit period.

// File: rtl/dmx_rx_pkg.sv
// Package: shared types and constants for the DMX512 slot receiver.
// Assumes: nothing; holds only definitions.
package dmx_rx_pkg;

    // Nominal DMX512 line rate in bits per second.
    localparam int unsigned DMX_LINE_BAUD = 250_000;

    // Number of slots kept: start code plus 512 channels plus two spare.
    localparam int unsigned DMX_SLOTS = 515;

    // Character receiver phases.
    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,   // hunting for a low start bit
        RX_START = 3'd1,   // inside the start bit
        RX_DATA  = 3'd2,   // inside one of the eight data bits
        RX_STOP1 = 3'd3,   // inside the first stop bit
        RX_STOP2 = 3'd4,   // inside the second stop bit
        RX_HOLD  = 3'd5    // after a framing error, waiting for idle-high
    } rx_phase_t;

endpackage

// File: rtl/dmx_line_sync.sv
// Module: dmx_line_sync
// Brings the asynchronous receive line into the clock domain through a
// chain of STAGES flops. Resets to the idle-high level so that reset
// release never looks like a start bit.
// Assumes: STAGES >= 2.
module dmx_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], line_i};
        end
    end

    assign line_o = chain[STAGES-1];

endmodule

// File: rtl/dmx_char_rx.sv
// Module: dmx_char_rx
// Deserialises one character: a start bit, eight data bits with the least
// significant bit first, and two stop bits. It takes three samples around
// the middle of every bit and decides the bit by majority vote. A low stop
// bit raises a framing error and parks the receiver until the line is high
// again. Disagreeing samples in a good character set a noise flag that is
// returned with the byte.
// Assumes: CLKS_PER_BIT >= 8; line_i is already synchronised.
module dmx_char_rx
    import dmx_rx_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    output logic       byte_vld_o,
    output logic [7:0] byte_o,
    output logic       noisy_o,
    output logic       ferr_o
);

    localparam int unsigned CW  = $clog2(CLKS_PER_BIT);
    localparam int unsigned MID = CLKS_PER_BIT / 2;

    rx_phase_t   phase;
    logic [CW-1:0] cnt;
    logic [2:0]  bit_idx;
    logic [7:0]  shreg;
    logic        smp_a;
    logic        smp_b;
    logic        noisy;

    logic at_a, at_b, at_eval, at_end;
    logic vote, agree;

    // Decode the sample points within the current bit and form the vote.
    always_comb begin
        at_a    = (cnt == CW'(MID - 1));
        at_b    = (cnt == CW'(MID));
        at_eval = (cnt == CW'(MID + 1));
        at_end  = (cnt == CW'(CLKS_PER_BIT - 1));
        vote    = (smp_a & smp_b) | (smp_a & line_i) | (smp_b & line_i);
        agree   = (smp_a == smp_b) && (smp_b == line_i);
    end

    // Phase sequencing, sampling, shifting and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= RX_IDLE;
            cnt        <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            smp_a      <= 1'b1;
            smp_b      <= 1'b1;
            noisy      <= 1'b0;
            byte_vld_o <= 1'b0;
            byte_o     <= '0;
            noisy_o    <= 1'b0;
            ferr_o     <= 1'b0;
        end else begin
            byte_vld_o <= 1'b0;
            noisy_o    <= 1'b0;
            ferr_o     <= 1'b0;
            case (phase)
                RX_IDLE: begin
                    cnt     <= '0;
                    bit_idx <= '0;
                    noisy   <= 1'b0;
                    if (!line_i) begin
                        phase <= RX_START;
                    end
                end
                RX_HOLD: begin
                    cnt <= '0;
                    if (line_i) begin
                        phase <= RX_IDLE;
                    end
                end
                default: begin
                    cnt <= at_end ? '0 : cnt + 1'b1;
                    if (at_a) smp_a <= line_i;
                    if (at_b) smp_b <= line_i;
                    if (at_end) begin
                        if (phase == RX_START) begin
                            phase <= RX_DATA;
                        end else if (phase == RX_DATA) begin
                            bit_idx <= bit_idx + 1'b1;
                            if (bit_idx == 3'd7) phase <= RX_STOP1;
                        end else if (phase == RX_STOP1) begin
                            phase <= RX_STOP2;
                        end
                    end
                    if (at_eval) begin
                        if (!agree) noisy <= 1'b1;
                        if (phase == RX_START) begin
                            if (vote) phase <= RX_IDLE;
                        end else if (phase == RX_DATA) begin
                            shreg <= {vote, shreg[7:1]};
                        end else if (phase == RX_STOP1) begin
                            if (!vote) begin
                                ferr_o <= 1'b1;
                                phase  <= RX_HOLD;
                            end
                        end else if (phase == RX_STOP2) begin
                            if (!vote) begin
                                ferr_o <= 1'b1;
                                phase  <= RX_HOLD;
                            end else begin
                                byte_vld_o <= 1'b1;
                                byte_o     <= shreg;
                                noisy_o    <= noisy | ~agree;
                                phase      <= RX_IDLE;
                            end
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/dmx_slot_store.sv
// Module: dmx_slot_store
// Holds the slot array and the write position. A good character is written
// at the position and the position advances, wrapping after DEPTH-1. A
// framing error returns the position to 0 and arms the frame-start pulse,
// which fires on the next good character. It keeps a copy of index 1 for
// the first-channel output and gives a registered read port.
// Assumes: DEPTH >= 2; a framing error and a good character never coincide.
module dmx_slot_store #(
    parameter int unsigned DEPTH = 515,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_vld_i,
    input  logic [7:0]    byte_i,
    input  logic          ferr_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o,
    output logic [7:0]    slot1_o,
    output logic [AW-1:0] wr_ptr_o,
    output logic          frame_start_o
);

    logic [7:0] mem [DEPTH];
    logic       armed;

    // Write a good character into the array.
    always_ff @(posedge clk) begin
        if (byte_vld_i) begin
            mem[wr_ptr_o] <= byte_i;
        end
    end

    // Registered read of the selected index; out-of-range reads return 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_addr_i < AW'(DEPTH)) begin
            rd_data_o <= mem[rd_addr_i];
        end else begin
            rd_data_o <= '0;
        end
    end

    // Position, frame-start arming and the first-channel copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_o      <= '0;
            armed         <= 1'b0;
            slot1_o       <= '0;
            frame_start_o <= 1'b0;
        end else begin
            frame_start_o <= 1'b0;
            if (ferr_i) begin
                wr_ptr_o <= '0;
                armed    <= 1'b1;
            end else if (byte_vld_i) begin
                wr_ptr_o      <= (wr_ptr_o == AW'(DEPTH - 1)) ? '0 : wr_ptr_o + 1'b1;
                frame_start_o <= armed;
                armed         <= 1'b0;
                if (wr_ptr_o == AW'(1)) begin
                    slot1_o <= byte_i;
                end
            end
        end
    end

endmodule

// File: rtl/dmx_slot_receiver.sv
// Module: dmx_slot_receiver (top)
// DMX512 receive path: line synchroniser, character deserialiser and slot
// store. The bit period is CLK_HZ / BAUD_HZ clocks.
// Assumes: CLK_HZ / BAUD_HZ >= 8; rx_i idles high.
module dmx_slot_receiver
    import dmx_rx_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 64_000_000,
    parameter int unsigned BAUD_HZ = DMX_LINE_BAUD,
    parameter int unsigned DEPTH   = DMX_SLOTS,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o,
    output logic [7:0]    slot1_o,
    output logic [AW-1:0] wr_ptr_o,
    output logic          frame_start_o,
    output logic          frame_err_o,
    output logic          noise_err_o
);

    localparam int unsigned CLKS_PER_BIT = CLK_HZ / BAUD_HZ;

    logic       rx_sync;
    logic       rx_vld;
    logic [7:0] rx_byte;
    logic       rx_noisy;
    logic       rx_ferr;

    dmx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_i),
        .line_o (rx_sync)
    );

    dmx_char_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_char (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (rx_sync),
        .byte_vld_o (rx_vld),
        .byte_o     (rx_byte),
        .noisy_o    (rx_noisy),
        .ferr_o     (rx_ferr)
    );

    dmx_slot_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .byte_vld_i    (rx_vld),
        .byte_i        (rx_byte),
        .ferr_i        (rx_ferr),
        .rd_addr_i     (rd_addr_i),
        .rd_data_o     (rd_data_o),
        .slot1_o       (slot1_o),
        .wr_ptr_o      (wr_ptr_o),
        .frame_start_o (frame_start_o)
    );

    assign frame_err_o = rx_ferr;
    assign noise_err_o = rx_noisy;

endmodule

// File: rtl/dmx_slot_receiver_chk.sv
// Module: dmx_slot_receiver_chk
// Temporal properties of the slot receiver, bound to the top module.
// Assumes: DEPTH >= 2.
module dmx_slot_receiver_chk #(
    parameter int unsigned DEPTH = 515,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] wr_ptr,
    input logic [7:0]    slot1,
    input logic          frame_start,
    input logic          frame_err,
    input logic          noise_err,
    input logic          byte_vld,
    input logic [7:0]    byte_data
);

    // R2: position stays inside the array
    a_r2_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr < AW'(DEPTH));

    // R2: a good character below the top index advances the position by one
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !frame_err && wr_ptr != AW'(DEPTH - 1)) |=> wr_ptr == $past(wr_ptr) + 1'b1);

    // R3: a character at the top index wraps the position to zero
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && wr_ptr == AW'(DEPTH - 1)) |=> wr_ptr == '0);

    // R4: a framing error restarts the position at zero
    a_r4_ferr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> wr_ptr == '0);

    // R4: a framing error never comes with a stored character
    a_r4_ferr_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_err, byte_vld}));

    // R5: the frame-start pulse comes with index 0 just written
    a_r5_frame_start_pos: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> wr_ptr == AW'(1));

    // R6: writing index 1 updates the first-channel output
    a_r6_slot1_update: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && wr_ptr == AW'(1)) |=> slot1 == $past(byte_data));

    // R7: the noise pulse only comes with a stored character
    a_r7_noise_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        noise_err |-> byte_vld);

endmodule

bind dmx_slot_receiver dmx_slot_receiver_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ptr      (wr_ptr_o),
    .slot1       (slot1_o),
    .frame_start (frame_start_o),
    .frame_err   (frame_err_o),
    .noise_err   (noise_err_o),
    .byte_vld    (rx_vld),
    .byte_data   (rx_byte)
);

// File: tb/test_dmx_slot_receiver.sv
module test_dmx_slot_receiver;

    localparam int unsigned CLK_HZ  = 50_000_000;
    localparam int unsigned BAUD_HZ = 3_125_000;
    localparam int unsigned DEPTH   = 515;
    localparam int unsigned AW      = $clog2(DEPTH);
    localparam int          BITCLK  = CLK_HZ / BAUD_HZ;   // 16 clocks per bit

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data, slot1;
    logic [AW-1:0] wr_ptr;
    logic          frame_start, frame_err, noise_err;

    always #10 clk = ~clk;   // 50 MHz

    dmx_slot_receiver #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ), .DEPTH(DEPTH)) i_dmx_slot_receiver (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_i          (rx),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data),
        .slot1_o       (slot1),
        .wr_ptr_o      (wr_ptr),
        .frame_start_o (frame_start),
        .frame_err_o   (frame_err),
        .noise_err_o   (noise_err)
    );

    // Reference model state.
    int  exp_mem [DEPTH];
    int  exp_ptr = 0;
    int  exp_slot1 = 0;
    bit  exp_armed = 1'b0;
    int  exp_fs = 0, exp_fe = 0, exp_ne = 0;
    int  act_fs = 0, act_fe = 0, act_ne = 0;
    bit  model_sync = 1'b0;
    bit  done = 1'b0;
    int  checks = 0;
    int  failures = 0;

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Every clock: count pulses and compare position and first channel.
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_start) act_fs++;
            if (frame_err)   act_fe++;
            if (noise_err)   act_ne++;
            if (model_sync) begin
                check("R2 wr_ptr per clock", int'(wr_ptr), exp_ptr);
                check("R6 slot1 per clock", int'(slot1), exp_slot1);
            end
        end
    end

    // One bit; glitch inverts the line for the centre sample clock only.
    task automatic drive_bit(input logic v, input bit glitch);
        for (int k = 0; k < BITCLK; k++) begin
            @(negedge clk);
            rx = (glitch && k == 9) ? ~v : v;
        end
    endtask

    // One character; stop_ok=0 drives the first stop bit low.
    task automatic send_char(input logic [7:0] b, input bit stop_ok, input int glitch_bit);
        model_sync = 1'b0;
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i], glitch_bit == i);
        drive_bit(stop_ok, 1'b0);
        drive_bit(1'b1, 1'b0);
        for (int k = 0; k < 4; k++) @(negedge clk);
        if (stop_ok) begin
            exp_mem[exp_ptr] = int'(b);
            if (exp_ptr == 1) exp_slot1 = int'(b);
            if (exp_armed) begin
                exp_fs++;
                exp_armed = 1'b0;
            end
            if (glitch_bit >= 0) exp_ne++;
            exp_ptr = (exp_ptr + 1) % DEPTH;
        end else begin
            exp_fe++;
            exp_ptr = 0;
            exp_armed = 1'b1;
        end
        model_sync = 1'b1;
    endtask

    task automatic send_break();
        model_sync = 1'b0;
        for (int k = 0; k < 22 * BITCLK; k++) begin
            @(negedge clk);
            rx = 1'b0;
        end
        for (int k = 0; k < 2 * BITCLK; k++) begin
            @(negedge clk);
            rx = 1'b1;
        end
        exp_fe++;
        exp_ptr = 0;
        exp_armed = 1'b1;
        model_sync = 1'b1;
    endtask

    task automatic read_check(input string req, input int idx);
        @(negedge clk);
        rd_addr = AW'(idx);
        @(negedge clk);
        check(req, int'(rd_data), exp_mem[idx]);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 0;
        repeat (5) @(negedge clk);
        // R10: reset state
        check("R10 wr_ptr after reset", int'(wr_ptr), 0);
        check("R10 slot1 after reset", int'(slot1), 0);
        check("R10 pulses low after reset", int'({frame_start, frame_err, noise_err}), 0);
        rst_n = 1'b1;
        model_sync = 1'b1;

        // R2, R6: characters before any break, no frame-start pulse
        send_char(8'h11, 1'b1, -1);
        send_char(8'h22, 1'b1, -1);
        check("R5 no pulse before break", act_fs, 0);
        read_check("R2 index 0 after first char", 0);

        // R8: short low glitch is not a start bit
        model_sync = 1'b0;
        for (int k = 0; k < 3; k++) begin @(negedge clk); rx = 1'b0; end
        for (int k = 0; k < 3 * BITCLK; k++) begin @(negedge clk); rx = 1'b1; end
        model_sync = 1'b1;
        check("R8 position kept after false start", int'(wr_ptr), 2);

        // R4, R11: break restarts frame, single error pulse
        send_break();
        check("R11 one error pulse per break", act_fe, 1);
        check("R4 position zero after break", int'(wr_ptr), 0);

        // R1, R5, R6: start code and channels, LSB-first check via 0x81 / 0x3C
        send_char(8'h00, 1'b1, -1);
        send_char(8'hA5, 1'b1, -1);
        send_char(8'h3C, 1'b1, -1);
        send_char(8'h81, 1'b1, -1);
        check("R5 one frame-start pulse", act_fs, exp_fs);
        check("R6 slot1 holds channel one", int'(slot1), 8'hA5);
        read_check("R9 readback start code", 0);
        read_check("R1 readback 0x3C", 2);
        read_check("R1 readback 0x81", 3);
        @(negedge clk); rd_addr = AW'(DEPTH + 3);
        @(negedge clk); check("R9 out-of-range read is zero", int'(rd_data), 0);

        // R7: one-sample glitch on data bit 1 flags noise, value kept
        send_char(8'h5A, 1'b1, 1);
        check("R7 noise pulse count", act_ne, 1);
        read_check("R7 noisy byte stored by vote", 4);

        // R4: a bad stop bit is not stored; index 1 keeps its value
        send_break();
        send_char(8'h66, 1'b1, -1);
        send_char(8'h99, 1'b0, -1);
        check("R4 error count after bad stop", act_fe, exp_fe);
        check("R4 position zero after bad stop", int'(wr_ptr), 0);
        read_check("R4 index 1 unchanged by bad char", 1);
        check("R4 slot1 unchanged by bad char", int'(slot1), 8'hA5);

        // R3: DEPTH+1 characters wrap the position
        send_break();
        for (int i = 0; i <= DEPTH; i++) send_char(8'((i * 7 + 3) & 8'hFF), 1'b1, -1);
        check("R3 position after wrap", int'(wr_ptr), 1);
        read_check("R3 index 0 overwritten after wrap", 0);
        read_check("R3 top index", DEPTH - 1);
        check("R5 pulse count over all frames", act_fs, exp_fs);
        check("R7 noise count final", act_ne, exp_ne);
        check("R4 error count final", act_fe, exp_fe);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190_000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule